// File: doc/BRIEF.md
# Pseudo-Associative Second-Level Translation Buffer

This block is a 64-slot address translation cache that serves both instruction fetches and data accesses. A lookup presents an address-space identifier, a virtual page number and an access kind. The block answers with a hit (physical page number, permission bits, attribute bits), a miss, or a page fault. Each virtual page can live in one of two slots. The first slot is indexed by the low six VPN bits. The second slot is indexed by those bits XORed with the next six. The two slots are probed one after the other, so a translation found in the first slot answers faster.

A hardware table walker fills slots through a refill write port. Software has no path to write entries. A fence port removes entries. It can remove every entry, the entries of one page, the non-global entries of one address space, or the entries matching both a page and an address space. Accessed and dirty bits are not updated in hardware. A hit whose page breaks the accessed or dirty rule is reported as a page fault.

Lookup requests, responses and refills move over valid/ready channels. A lookup is taken when `lk_valid` and `lk_ready` are both high at a clock edge. Only one lookup is in flight, and `lk_ready` stays low until its response has been consumed. A response stays on the pins, unchanged, until `rsp_ready` is high at an edge. A refill is written at an edge where `rf_valid` and `rf_ready` are both high. `rf_ready` is pulled low only during a cycle in which a fence is applied. The fence is a single-cycle control strobe with no handshake.

Top module: `pa_tlb`

## Requirements
- R1: After reset every slot is invalid, `lk_ready` is 1 and `rsp_valid` is 0. `lk_ready` and `rsp_valid` are never high together. A response held under `rsp_ready`=0 keeps `rsp_kind` and `rsp_ppn` stable.
- R2: When the first slot (index VPN[5:0]) holds a match, `rsp_valid` rises one cycle after the lookup is accepted.
- R3: When the first slot does not match, the second slot (index VPN[5:0] XOR VPN[11:6]) is probed. The result then appears two cycles after acceptance. A miss (`rsp_kind`=1) is reported only after both slots fail.
- R4: A slot matches when it is valid, its VPN equals the request VPN, and either its ASID equals the request ASID or its global flag is set.
- R5: A matching entry with its accessed flag clear yields a fault (`rsp_kind`=2) for any access kind. Every non-hit response drives `rsp_ppn`, `rsp_perm` and `rsp_attr` to zero.
- R6: For a store (`lk_acc`=2), a matching entry with its dirty flag clear yields a fault. For a fetch (`lk_acc`=0) or a load (`lk_acc`=1) on the same entry, the result is a hit (`rsp_kind`=0) with the stored PPN.
- R7: A refill writes the first slot if that slot is invalid. Otherwise it writes the second slot, replacing any entry already there.
- R8: `rf_ready` is 0 in any cycle with `fn_valid`=1, and 1 otherwise.
- R9: A fence with both `fn_use_addr` and `fn_use_asid` at 0 invalidates every slot.
- R10: A fence with only `fn_use_addr` set invalidates every entry whose VPN equals `fn_vpn`, whatever its ASID or global flag.
- R11: A fence with only `fn_use_asid` set invalidates the non-global entries whose ASID equals `fn_asid`. Global entries survive.
- R12: A fence with both flags set invalidates the non-global entries that match both `fn_vpn` and `fn_asid`. Entries that differ in either field survive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request accepted |
| lk_asid | input | 9 | Lookup address-space identifier |
| lk_vpn | input | 27 | Lookup virtual page number |
| lk_acc | input | 2 | Access kind: 0 fetch, 1 load, 2 store |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumed |
| rsp_kind | output | 2 | 0 hit, 1 miss, 2 fault |
| rsp_ppn | output | 44 | Physical page number on hit |
| rsp_perm | output | 3 | Permission bits on hit |
| rsp_attr | output | 3 | Storage attribute bits on hit |
| rf_valid | input | 1 | Refill write valid |
| rf_ready | output | 1 | Refill write accepted |
| rf_asid | input | 9 | Refill ASID |
| rf_vpn | input | 27 | Refill VPN |
| rf_ppn | input | 44 | Refill PPN |
| rf_perm | input | 3 | Refill permission bits |
| rf_attr | input | 3 | Refill attribute bits |
| rf_g | input | 1 | Refill global flag |
| rf_a | input | 1 | Refill accessed flag |
| rf_d | input | 1 | Refill dirty flag |
| fn_valid | input | 1 | Fence strobe, applied in the same cycle |
| fn_use_addr | input | 1 | Fence qualified by VPN |
| fn_use_asid | input | 1 | Fence qualified by ASID |
| fn_vpn | input | 27 | Fence VPN |
| fn_asid | input | 9 | Fence ASID |

## Verification
The assertions check the handshake rules on every cycle. Lookup acceptance and a pending response never overlap. A stalled response is held stable, and at least one probe cycle separates acceptance from the response. Every non-hit response carries a zero page number. A fence blocks refills, and an unqualified fence leaves every slot invalid on the next edge. The bench scenarios are needed to show the rest: the slot-selection and replacement order, the one-cycle versus two-cycle answer latency, the ASID and global matching, the accessed and dirty fault rules, and which entries each qualified fence form removes or keeps.

// File: rtl/pa_tlb_pkg.sv
package pa_tlb_pkg;
  parameter int ASID_W = 9;
  parameter int VPN_W  = 27;
  parameter int PPN_W  = 44;
  parameter int PERM_W = 3;
  parameter int ATTR_W = 3;

  typedef enum logic [1:0] {ACC_FETCH = 2'd0, ACC_LOAD = 2'd1, ACC_STORE = 2'd2} acc_e;
  typedef enum logic [1:0] {RK_HIT = 2'd0, RK_MISS = 2'd1, RK_FAULT = 2'd2} rkind_e;

  typedef struct packed {
    logic              g;
    logic              a;
    logic              d;
    logic [ASID_W-1:0] asid;
    logic [VPN_W-1:0]  vpn;
    logic [PPN_W-1:0]  ppn;
    logic [PERM_W-1:0] perm;
    logic [ATTR_W-1:0] attr;
  } tent_t;
endpackage

// File: rtl/pa_tlb_hash.sv
module pa_tlb_hash #(
  parameter int IDX_W = 6
) (
  input  logic [2*IDX_W-1:0] vpn_lo,
  output logic [IDX_W-1:0]   first_idx,
  output logic [IDX_W-1:0]   second_idx
);
  assign first_idx  = vpn_lo[IDX_W-1:0];
  assign second_idx = vpn_lo[IDX_W-1:0] ^ vpn_lo[2*IDX_W-1:IDX_W];
endmodule

// File: rtl/pa_tlb_match.sv
module pa_tlb_match
  import pa_tlb_pkg::*;
(
  input  logic              slot_vld,
  input  logic              e_g,
  input  logic              e_a,
  input  logic              e_d,
  input  logic [ASID_W-1:0] e_asid,
  input  logic [VPN_W-1:0]  e_vpn,
  input  logic [ASID_W-1:0] q_asid,
  input  logic [VPN_W-1:0]  q_vpn,
  input  logic [1:0]        q_acc,
  output logic              hit,
  output logic              fault
);
  always_comb begin
    hit   = slot_vld && (e_vpn == q_vpn) && (e_g || (e_asid == q_asid));
    fault = hit && (!e_a || ((q_acc == ACC_STORE) && !e_d));
  end
endmodule

// File: rtl/pa_tlb_store.sv
module pa_tlb_store
  import pa_tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [IDX_W-1:0]   rd_idx,
  output tent_t              rd_ent,
  output logic [ENTRIES-1:0] vld,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  tent_t              wr_ent,
  input  logic               fn_valid,
  input  logic               fn_use_addr,
  input  logic               fn_use_asid,
  input  logic [VPN_W-1:0]   fn_vpn,
  input  logic [ASID_W-1:0]  fn_asid
);
  tent_t              ents [ENTRIES];
  logic [ENTRIES-1:0] vld_nxt;
  logic [ENTRIES-1:0] kill;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_kill
    logic addr_ok, asid_ok;
    always_comb begin
      addr_ok = !fn_use_addr || (ents[i].vpn == fn_vpn);
      asid_ok = !fn_use_asid || ((ents[i].asid == fn_asid) && !ents[i].g);
      kill[i] = fn_valid && addr_ok && asid_ok;
    end
  end

  always_comb begin
    vld_nxt = vld & ~kill;
    if (wr_en) vld_nxt[wr_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) vld <= '0;
    else        vld <= vld_nxt;
  end

  always_ff @(posedge clk) begin
    if (wr_en) ents[wr_idx] <= wr_ent;
  end

  assign rd_ent = ents[rd_idx];
endmodule

// File: rtl/pa_tlb.sv
module pa_tlb
  import pa_tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [1:0]        lk_acc,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [1:0]        rsp_kind,
  output logic [PPN_W-1:0]  rsp_ppn,
  output logic [PERM_W-1:0] rsp_perm,
  output logic [ATTR_W-1:0] rsp_attr,
  input  logic              rf_valid,
  output logic              rf_ready,
  input  logic [ASID_W-1:0] rf_asid,
  input  logic [VPN_W-1:0]  rf_vpn,
  input  logic [PPN_W-1:0]  rf_ppn,
  input  logic [PERM_W-1:0] rf_perm,
  input  logic [ATTR_W-1:0] rf_attr,
  input  logic              rf_g,
  input  logic              rf_a,
  input  logic              rf_d,
  input  logic              fn_valid,
  input  logic              fn_use_addr,
  input  logic              fn_use_asid,
  input  logic [VPN_W-1:0]  fn_vpn,
  input  logic [ASID_W-1:0] fn_asid
);
  typedef enum logic [1:0] {S_IDLE, S_PRB1, S_PRB2, S_RESP} st_e;

  st_e               state;
  logic [ASID_W-1:0] q_asid;
  logic [VPN_W-1:0]  q_vpn;
  logic [1:0]        q_acc;
  logic [1:0]        r_kind;
  logic [PPN_W-1:0]  r_ppn;
  logic [PERM_W-1:0] r_perm;
  logic [ATTR_W-1:0] r_attr;

  logic [IDX_W-1:0]   q_first, q_second, rd_idx;
  logic [IDX_W-1:0]   f_first, f_second, wr_idx;
  logic [ENTRIES-1:0] ent_vld;
  tent_t              rd_ent, wr_ent;
  logic               wr_en, m_hit, m_fault;

  pa_tlb_hash #(.IDX_W(IDX_W)) u_qhash (
    .vpn_lo(q_vpn[2*IDX_W-1:0]), .first_idx(q_first), .second_idx(q_second));

  pa_tlb_hash #(.IDX_W(IDX_W)) u_fhash (
    .vpn_lo(rf_vpn[2*IDX_W-1:0]), .first_idx(f_first), .second_idx(f_second));

  assign rf_ready = !fn_valid;
  assign wr_en    = rf_valid && rf_ready;
  assign wr_idx   = !ent_vld[f_first] ? f_first : f_second;

  always_comb begin
    wr_ent      = '0;
    wr_ent.g    = rf_g;
    wr_ent.a    = rf_a;
    wr_ent.d    = rf_d;
    wr_ent.asid = rf_asid;
    wr_ent.vpn  = rf_vpn;
    wr_ent.ppn  = rf_ppn;
    wr_ent.perm = rf_perm;
    wr_ent.attr = rf_attr;
  end

  assign rd_idx = (state == S_PRB2) ? q_second : q_first;

  pa_tlb_store #(.ENTRIES(ENTRIES)) u_store (
    .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx), .rd_ent(rd_ent), .vld(ent_vld),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_ent(wr_ent),
    .fn_valid(fn_valid), .fn_use_addr(fn_use_addr), .fn_use_asid(fn_use_asid),
    .fn_vpn(fn_vpn), .fn_asid(fn_asid));

  pa_tlb_match u_match (
    .slot_vld(ent_vld[rd_idx]), .e_g(rd_ent.g), .e_a(rd_ent.a), .e_d(rd_ent.d),
    .e_asid(rd_ent.asid), .e_vpn(rd_ent.vpn),
    .q_asid(q_asid), .q_vpn(q_vpn), .q_acc(q_acc),
    .hit(m_hit), .fault(m_fault));

  logic ok_hit;
  assign ok_hit = m_hit && !m_fault;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      q_asid <= '0;
      q_vpn  <= '0;
      q_acc  <= '0;
      r_kind <= RK_MISS;
      r_ppn  <= '0;
      r_perm <= '0;
      r_attr <= '0;
    end else begin
      case (state)
        S_IDLE: if (lk_valid) begin
          q_asid <= lk_asid;
          q_vpn  <= lk_vpn;
          q_acc  <= lk_acc;
          state  <= S_PRB1;
        end
        S_PRB1, S_PRB2: begin
          if (m_hit || state == S_PRB2) begin
            r_kind <= !m_hit ? RK_MISS : (m_fault ? RK_FAULT : RK_HIT);
            r_ppn  <= ok_hit ? rd_ent.ppn  : '0;
            r_perm <= ok_hit ? rd_ent.perm : '0;
            r_attr <= ok_hit ? rd_ent.attr : '0;
            state  <= S_RESP;
          end else begin
            state  <= S_PRB2;
          end
        end
        default: if (rsp_ready) state <= S_IDLE;
      endcase
    end
  end

  assign lk_ready  = (state == S_IDLE);
  assign rsp_valid = (state == S_RESP);
  assign rsp_kind  = r_kind;
  assign rsp_ppn   = r_ppn;
  assign rsp_perm  = r_perm;
  assign rsp_attr  = r_attr;
endmodule

// File: rtl/pa_tlb_chk.sv
module pa_tlb_chk #(
  parameter int ENTRIES = 64,
  parameter int PPN_W   = 44
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lk_valid,
  input logic               lk_ready,
  input logic               rsp_valid,
  input logic               rsp_ready,
  input logic [1:0]         rsp_kind,
  input logic [PPN_W-1:0]   rsp_ppn,
  input logic               rf_ready,
  input logic               fn_valid,
  input logic               fn_use_addr,
  input logic               fn_use_asid,
  input logic [ENTRIES-1:0] ent_vld
);
  a_r1_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_ready && rsp_valid));

  a_r1_hold_resp: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_kind) && $stable(rsp_ppn)));

  a_r2_probe_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready) |=> (!rsp_valid && !lk_ready));

  a_r5_nonhit_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_kind != 2'd0) |-> (rsp_ppn == '0));

  a_r8_fence_blocks_refill: assert property (@(posedge clk) disable iff (!rst_n)
    fn_valid |-> !rf_ready);

  a_r9_flush_all: assert property (@(posedge clk) disable iff (!rst_n)
    (fn_valid && !fn_use_addr && !fn_use_asid) |=> (ent_vld == '0));
endmodule

bind pa_tlb pa_tlb_chk #(.ENTRIES(ENTRIES), .PPN_W(pa_tlb_pkg::PPN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(lk_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_kind(rsp_kind), .rsp_ppn(rsp_ppn),
  .rf_ready(rf_ready), .fn_valid(fn_valid), .fn_use_addr(fn_use_addr),
  .fn_use_asid(fn_use_asid), .ent_vld(ent_vld));

// File: tb/pa_tlb_tb_top.sv
`timescale 1ns/1ps
module pa_tlb_tb_top;
  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic        lk_valid = 0, rsp_ready = 1, rf_valid = 0, fn_valid = 0;
  logic        lk_ready, rsp_valid, rf_ready;
  logic [8:0]  lk_asid = 0, rf_asid = 0, fn_asid = 0;
  logic [26:0] lk_vpn = 0, rf_vpn = 0, fn_vpn = 0;
  logic [1:0]  lk_acc = 0, rsp_kind;
  logic [43:0] rsp_ppn, rf_ppn = 0;
  logic [2:0]  rsp_perm, rsp_attr, rf_perm = 3'b011, rf_attr = 3'b101;
  logic        rf_g = 0, rf_a = 1, rf_d = 1, fn_use_addr = 0, fn_use_asid = 0;

  pa_tlb dut_i (.*);

  int n_tests = 0, n_fail = 0, cyc = 0, acc_cyc = 0;
  int q_kind[$], q_lat[$];
  logic [43:0] q_ppn[$];
  string q_tag[$];
  bit done = 0;

  always @(posedge clk) cyc++;

  task automatic check(bit ok, string tag, longint act, longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready && q_kind.size() != 0) begin
      int ek, el; logic [43:0] ep; string t;
      ek = q_kind.pop_front(); el = q_lat.pop_front();
      ep = q_ppn.pop_front();  t = q_tag.pop_front();
      check(rsp_kind == ek[1:0], {t, " kind"}, rsp_kind, ek);
      check(rsp_ppn == ep, {t, " ppn"}, rsp_ppn, ep);
      if (el >= 0) check(cyc - acc_cyc == el, {t, " latency"}, cyc - acc_cyc, el);
    end
  end

  task automatic push(int k, logic [43:0] p, int l, string t);
    q_kind.push_back(k); q_ppn.push_back(p); q_lat.push_back(l); q_tag.push_back(t);
  endtask

  task automatic send(logic [8:0] asid, logic [26:0] vpn, logic [1:0] acc);
    @(negedge clk);
    lk_valid = 1; lk_asid = asid; lk_vpn = vpn; lk_acc = acc;
    while (!lk_ready) @(negedge clk);
    acc_cyc = cyc + 1;
    @(negedge clk);
    lk_valid = 0;
  endtask

  task automatic lookup(logic [8:0] asid, logic [26:0] vpn, logic [1:0] acc,
                        int ek, logic [43:0] ep, int el, string t);
    push(ek, ep, el, t);
    send(asid, vpn, acc);
    while (q_kind.size() != 0) @(negedge clk);
  endtask

  task automatic refill(logic [8:0] asid, logic [26:0] vpn, logic [43:0] ppn,
                        logic g, logic a, logic d);
    @(negedge clk);
    rf_valid = 1; rf_asid = asid; rf_vpn = vpn; rf_ppn = ppn; rf_g = g; rf_a = a; rf_d = d;
    while (!rf_ready) @(negedge clk);
    @(negedge clk);
    rf_valid = 0;
  endtask

  task automatic fence(logic ua, logic us, logic [26:0] vpn, logic [8:0] asid);
    @(negedge clk);
    fn_valid = 1; fn_use_addr = ua; fn_use_asid = us; fn_vpn = vpn; fn_asid = asid;
    @(negedge clk);
    fn_valid = 0; fn_use_addr = 0; fn_use_asid = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(lk_ready == 1, "R1 reset lk_ready", lk_ready, 1);
    check(rsp_valid == 0, "R1 reset rsp_valid", rsp_valid, 0);
    lookup(9'd1, 27'h45, 2'd1, 1, 0, 2, "R1 R3 empty miss");

    // R7: 0x00045, 0x01045, 0x02045 share first slot 5 and second slot 4
    refill(9'd1, 27'h00045, 44'h100, 0, 1, 1);
    refill(9'd1, 27'h01045, 44'h200, 0, 1, 1);
    lookup(9'd1, 27'h00045, 2'd1, 0, 44'h100, 1, "R2 R7 first slot hit");
    lookup(9'd1, 27'h01045, 2'd0, 0, 44'h200, 2, "R3 R7 second slot hit");
    refill(9'd1, 27'h02045, 44'h300, 0, 1, 1);
    lookup(9'd1, 27'h01045, 2'd1, 1, 0, 2, "R7 second slot replaced");
    lookup(9'd1, 27'h02045, 2'd1, 0, 44'h300, 2, "R7 new second entry");
    lookup(9'd1, 27'h00045, 2'd1, 0, 44'h100, 1, "R7 first slot kept");

    // R4 ASID and global matching
    lookup(9'd2, 27'h00045, 2'd1, 1, 0, 2, "R4 asid mismatch miss");
    refill(9'd7, 27'h00080, 44'h400, 1, 1, 1);
    lookup(9'd3, 27'h00080, 2'd1, 0, 44'h400, 1, "R4 global any asid");

    // R5 accessed clear, R6 dirty clear
    refill(9'd1, 27'h00011, 44'h500, 0, 0, 1);
    lookup(9'd1, 27'h00011, 2'd0, 2, 0, 1, "R5 accessed clear fault");
    refill(9'd1, 27'h00012, 44'h600, 0, 1, 0);
    lookup(9'd1, 27'h00012, 2'd2, 2, 0, 1, "R6 store dirty clear fault");
    lookup(9'd1, 27'h00012, 2'd1, 0, 44'h600, 1, "R6 load dirty clear hit");
    lookup(9'd1, 27'h00012, 2'd0, 0, 44'h600, 1, "R6 fetch dirty clear hit");

    // R1 stall hold
    rsp_ready = 0;
    push(0, 44'h600, -1, "R1 stalled response");
    send(9'd1, 27'h00012, 2'd1);
    repeat (4) @(negedge clk);
    check(rsp_valid == 1, "R1 held valid", rsp_valid, 1);
    check(lk_ready == 0, "R1 busy while held", lk_ready, 0);
    rsp_ready = 1;
    while (q_kind.size() != 0) @(negedge clk);

    // R11 fence by asid
    refill(9'd3, 27'h00020, 44'h700, 0, 1, 1);
    refill(9'd3, 27'h00021, 44'h701, 1, 1, 1);
    fence(0, 1, 27'h0, 9'd3);
    lookup(9'd3, 27'h00020, 2'd1, 1, 0, 2, "R11 asid entry removed");
    lookup(9'd3, 27'h00021, 2'd1, 0, 44'h701, 1, "R11 global kept");

    // R10 fence by address removes global
    fence(1, 0, 27'h00021, 9'd0);
    lookup(9'd3, 27'h00021, 2'd1, 1, 0, 2, "R10 address fence");
    lookup(9'd1, 27'h00012, 2'd1, 0, 44'h600, 1, "R10 other page kept");

    // R12 fence by both
    refill(9'd4, 27'h00022, 44'h800, 0, 1, 1);
    refill(9'd4, 27'h00023, 44'h801, 0, 1, 1);
    refill(9'd5, 27'h00024, 44'h802, 0, 1, 1);
    fence(1, 1, 27'h00022, 9'd4);
    fence(1, 1, 27'h00024, 9'd6);
    lookup(9'd4, 27'h00022, 2'd1, 1, 0, 2, "R12 both match removed");
    lookup(9'd4, 27'h00023, 2'd1, 0, 44'h801, 1, "R12 other vpn kept");
    lookup(9'd5, 27'h00024, 2'd1, 0, 44'h802, 1, "R12 other asid kept");

    // R8 refill blocked during fence, R9 flush all
    @(negedge clk);
    fn_valid = 1; fn_use_addr = 0; fn_use_asid = 0;
    #0.5;
    check(rf_ready == 0, "R8 rf_ready low in fence", rf_ready, 0);
    @(negedge clk);
    fn_valid = 0;
    #0.5;
    check(rf_ready == 1, "R8 rf_ready high otherwise", rf_ready, 1);
    lookup(9'd4, 27'h00023, 2'd1, 1, 0, 2, "R9 flush all");
    lookup(9'd1, 27'h00045, 2'd1, 1, 0, 2, "R9 flush all first slot");
    lookup(9'd3, 27'h00080, 2'd1, 1, 0, 2, "R9 flush all global");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule